// File: doc/BRIEF.md
# Programmable bus clock prescaler

This block derives a clock-enable for a bus or CPU domain from the system clock. Software picks a division ratio by writing a 4-bit code into an 8-bit control word. The block then issues a one-cycle enable pulse once every N system-clock cycles. Besides powers of two from 2 to 512, the code set includes the ratios 3, 5, 6, 10 and 32. Three codes select the undivided setting, in which the enable stays high on every cycle.

A ratio change is never applied in the middle of a division period. The period that is running finishes with the old ratio, and the new ratio starts at the next boundary. A status output drops when software writes the code and rises again in the first cycle the new ratio is in force, so software can poll it after each write. On entry into a low-power stop state, when the fast internal oscillator is the chosen wake-up clock, the block forces the code back to undivided.

Top module: `bus_ratio_prescaler`

## Requirements
- R1: Code bits [3:0] select the ratio. 0001=/3, 0010=/5, 0101=/6, 0110=/10, 0111=/32, 1000=/2, 1001=/4, 1010=/8, 1011=/16, 1100=/64, 1101=/128, 1110=/256, 1111=/512. Codes 0000, 0011 and 0100 select /1 (undivided).
- R2: With ratio N>1 in force, `clk_en_out` is high for exactly one cycle in every N cycles. With ratio 1 it is high on every cycle.
- R3: A code change made mid-period does not alter that period. The spacing that ends the current period is the old N, and the following spacing uses the new ratio.
- R4: `ratio_applied` is low from the cycle after a code write or a forced clear until the new ratio takes effect. It rises in the first cycle of the first period that runs at the new ratio.
- R5: When `lp_entry` and `wake_fast_osc` are both high at a clock edge, the code becomes 0000 and `ratio_applied` drops as it does for a write. `lp_entry` while `wake_fast_osc` is low leaves the code and the flag unchanged.
- R6: A forced clear wins over a software write in the same cycle. The code becomes 0000.
- R7: Control-word bits [7:4] are reserved. Their write value is ignored and they read back as 0. `rd_data[3:0]` returns the current code.
- R8: After reset the code is 0000, `ratio_applied` is 1, and `clk_en_out` is high in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word; bits [3:0] are the ratio code |
| rd_data | output | 8 | Control word readback; reserved bits read 0 |
| lp_entry | input | 1 | Low-power stop entry event |
| wake_fast_osc | input | 1 | Fast internal oscillator is the selected wake-up clock |
| clk_en_out | output | 1 | Divided clock-enable pulse |
| ratio_applied | output | 1 | High when the last written ratio is in use |

## Verification
The hardest case to reach is a ratio change that lands deep inside a long period, so that the old spacing must still be seen to finish before the new one starts. The bench first settles the divider on /10. It waits for a pulse, writes /3 three cycles later, and measures two successive spacings (10, then 3), checking the flag at each step. A behavioural model compares every output on every cycle during all tests. This covers writes that coincide with a boundary pulse, the clear that overrides a write, and the sweep that measures the spacing for all sixteen codes.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  localparam int CODE_W    = 4;
  localparam int WORD_W    = 8;
  localparam int MAX_RATIO = 512;
  localparam int LEN_W     = $clog2(MAX_RATIO) + 1;

  // Ratio selected by a code; R1
  function automatic logic [LEN_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
    logic [LEN_W-1:0] r;
    r = LEN_W'(1);
    if (c[3]) begin
      // binary ratios: exponent skips 5 (32 sits among the odd codes)
      r = LEN_W'(1) << (32'(c[2:0]) + (c[2] ? 32'd2 : 32'd1));
    end else begin
      case (c[2:0])
        3'd1:    r = LEN_W'(3);
        3'd2:    r = LEN_W'(5);
        3'd5:    r = LEN_W'(6);
        3'd6:    r = LEN_W'(10);
        3'd7:    r = LEN_W'(32);
        default: r = LEN_W'(1);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/ratio_code_reg.sv
module ratio_code_reg
  import prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              force_clr,
  output logic [CODE_W-1:0] code_o,
  output logic [WORD_W-1:0] rd_word,
  output logic              change_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (force_clr) code_q <= '0;
    else if (wr_en)     code_q <= wr_word[CODE_W-1:0];
  end

  assign code_o   = code_q;
  assign rd_word  = WORD_W'(code_q);
  assign change_o = wr_en | force_clr;

  p_force_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> (code_o == '0));
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !force_clr) |=> (code_o == $past(wr_word[CODE_W-1:0])));
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !force_clr) |=> $stable(rd_word));
endmodule

// File: rtl/ratio_period_counter.sv
module ratio_period_counter
  import prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic [LEN_W-1:0]  active_len_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] next_len;
  logic             boundary;

  assign next_len = ratio_of(code_i);
  assign boundary = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else if (boundary) begin
      len_q <= next_len;
      cnt_q <= next_len - LEN_W'(1);
    end else begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign tick_o       = boundary;
  assign active_len_o = len_q;

  p_hold_mid_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(active_len_o));
  p_unity_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_len_o == LEN_W'(1)) |-> tick_o);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ratio_of(code_i) != LEN_W'(1)) |=> !tick_o);
endmodule

// File: rtl/ratio_apply_flag.sv
module ratio_apply_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic change_i,
  input  logic load_i,
  output logic applied_o
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (change_i) pending_q <= 1'b1;
    else if (load_i)   pending_q <= 1'b0;
  end

  assign applied_o = ~pending_q;

  p_drop_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    change_i |=> !applied_o);
  p_rise_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !change_i) |=> applied_o);
endmodule

// File: rtl/bus_ratio_prescaler.sv
module bus_ratio_prescaler
  import prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              lp_entry,
  input  logic              wake_fast_osc,
  output logic              clk_en_out,
  output logic              ratio_applied
);
  logic              force_clr;
  logic              code_change;
  logic              period_tick;
  logic [CODE_W-1:0] cur_code;
  logic [LEN_W-1:0]  active_len;

  assign force_clr = lp_entry & wake_fast_osc;

  ratio_code_reg i_code (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_data),
    .force_clr(force_clr), .code_o(cur_code), .rd_word(rd_data),
    .change_o(code_change)
  );

  ratio_period_counter i_cnt (
    .clk(clk), .rst_n(rst_n), .code_i(cur_code),
    .tick_o(period_tick), .active_len_o(active_len)
  );

  ratio_apply_flag i_flag (
    .clk(clk), .rst_n(rst_n), .change_i(code_change),
    .load_i(period_tick), .applied_o(ratio_applied)
  );

  assign clk_en_out = period_tick;

  p_lp_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_entry && !wake_fast_osc && !wr_en) |=> $stable(rd_data));
  p_clear_beats_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_clr && wr_en) |=> (rd_data == '0 && !ratio_applied));
  p_applied_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_applied |-> (active_len == ratio_of(cur_code)));
endmodule

// File: tb/test_bus_ratio_prescaler.sv
module test_bus_ratio_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       lp_entry = 1'b0;
  logic       wake_fast_osc = 1'b0;
  logic       clk_en_out;
  logic       ratio_applied;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_len [16] = '{1, 3, 5, 1, 1, 6, 10, 32, 2, 4, 8, 16, 64, 128, 256, 512};

  always #5 clk = ~clk;

  bus_ratio_prescaler i_bus_ratio_prescaler (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lp_entry(lp_entry), .wake_fast_osc(wake_fast_osc),
    .clk_en_out(clk_en_out), .ratio_applied(ratio_applied)
  );

  // behavioural reference: cycles since last pulse, length of current period
  int m_code, m_len, m_since;
  bit m_pend, m_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_len = 1; m_since = 0; m_pend = 0;
    end else begin
      m_t = (m_since == m_len - 1);
      if (m_t) begin m_len = exp_len[m_code]; m_since = 0; m_pend = 0; end
      else m_since++;
      if (lp_entry && wake_fast_osc) begin m_code = 0; m_pend = 1; end
      else if (wr_en) begin m_code = int'(wr_data[3:0]); m_pend = 1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(clk_en_out == (m_since == m_len - 1), "R2 model tick", clk_en_out, m_since == m_len - 1);
    check(ratio_applied == !m_pend, "R4 model flag", ratio_applied, !m_pend);
    check(rd_data == 8'(m_code), "R7 model readback", rd_data, m_code);
  end

  task automatic write_word(input logic [7:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_applied();
    int n = 0;
    while (!ratio_applied && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int p);
    p = 0;
    do @(negedge clk); while (!clk_en_out);
    do begin @(negedge clk); p++; end while (!clk_en_out);
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(rd_data == 8'h00, "R8 reset code", rd_data, 0);
    check(ratio_applied == 1'b1, "R8 reset flag", ratio_applied, 1);
    check(clk_en_out == 1'b1, "R8 reset enable", clk_en_out, 1);

    // R1/R2 spacing for every code
    for (int c = 0; c < 16; c++) begin
      write_word(8'(c));
      wait_applied();
      measure(p);
      check(p == exp_len[c], "R1 ratio spacing", p, exp_len[c]);
      if (exp_len[c] == 1) check(clk_en_out == 1'b1, "R2 undivided high", clk_en_out, 1);
      else begin
        @(negedge clk);
        check(clk_en_out == 1'b0, "R2 single pulse", clk_en_out, 0);
      end
    end

    // R3/R4 mid-period change: /10 then /3
    write_word(8'h06);
    wait_applied();
    do @(negedge clk); while (!clk_en_out);
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    check(ratio_applied == 1'b0, "R4 flag drops", ratio_applied, 0);
    p = 3;
    while (!clk_en_out) begin @(negedge clk); p++; end
    check(p == 10, "R3 old period finishes", p, 10);
    check(ratio_applied == 1'b0, "R4 flag low at boundary", ratio_applied, 0);
    @(negedge clk);
    check(ratio_applied == 1'b1, "R4 flag rises", ratio_applied, 1);
    p = 1;
    while (!clk_en_out) begin @(negedge clk); p++; end
    check(p == 3, "R3 new period", p, 3);

    // R5 lp entry without fast wake clock: no effect
    write_word(8'h09);
    wait_applied();
    @(negedge clk); lp_entry = 1'b1; wake_fast_osc = 1'b0;
    @(negedge clk); lp_entry = 1'b0;
    check(rd_data == 8'h09, "R5 ignored code", rd_data, 9);
    check(ratio_applied == 1'b1, "R5 ignored flag", ratio_applied, 1);

    // R5 forced clear
    @(negedge clk); lp_entry = 1'b1; wake_fast_osc = 1'b1;
    @(negedge clk); lp_entry = 1'b0; wake_fast_osc = 1'b0;
    check(rd_data == 8'h00, "R5 forced clear", rd_data, 0);
    check(ratio_applied == 1'b0, "R5 flag drops", ratio_applied, 0);
    wait_applied();
    measure(p);
    check(p == 1, "R5 undivided after clear", p, 1);

    // R6 clear beats write
    write_word(8'h0F);
    wait_applied();
    @(negedge clk); lp_entry = 1'b1; wake_fast_osc = 1'b1; wr_en = 1'b1; wr_data = 8'h0B;
    @(negedge clk); lp_entry = 1'b0; wake_fast_osc = 1'b0; wr_en = 1'b0;
    check(rd_data == 8'h00, "R6 clear wins", rd_data, 0);

    // R7 reserved bits
    write_word(8'hF5);
    check(rd_data == 8'h05, "R7 reserved read zero", rd_data, 5);
    wait_applied();
    measure(p);
    check(p == 6, "R7 upper bits ignored", p, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule